// File: doc/BRIEF.md
# Interlaced Field Vertical Timing Generator

This block produces the vertical and field timing of an interlaced video frame that carries embedded timing codes. It keeps a frame line counter. The counter moves forward each time an enabled pixel arrives with horizontal position zero, and it returns to line 1 after the programmed frame height. Every vertical event is a set point or a clear point. Each point is a programmable pair of a line and a pixel position, so second-field edges can sit halfway along a line.

From these events the block drives several outputs:
- the blanking bit and the field bit that go into the timing codes;
- one external control pin that carries either vertical sync or vertical blank, with selectable polarity;
- one-cycle strobes that mark the start of each field;
- an image line counter with its qualifier.

Horizontal timing and data formatting belong to neighbouring blocks. All outputs change in the cycle after the enabled pixel that triggers them.

Top module: `vfield_timing_gen`

## Requirements
- R1: The line counter reads 0 after reset. On each cycle with `pix_en` high and `hpos` equal to 0 it advances to the next line. The line after the frame height is 1, so the first enabled pixel at position 0 after reset is on line 1.
- R2: `v_bit` goes to 1 after the enabled pixel at position 0 of line `vbit_on1` or of line `vbit_on2`. It goes to 0 after position 0 of line `vbit_off1` or of line `vbit_off2`.
- R3: `f_bit` goes to 1 after position 0 of line `fbit_on` and goes to 0 after position 0 of line `fbit_off`. It keeps its value across the frame wrap.
- R4: Vertical sync is active from pixel `vs_x1` of line `vs_top1` up to pixel `vs_x1` of line `vs_bot1` (start included, end excluded). A second window runs the same way with `vs_top2`, `vs_bot2` and `vs_x2`. Sync is the OR of the two windows.
- R5: Vertical blank follows the same rule as R4, using `vb_top1`, `vb_bot1`, `vb_x1` and `vb_top2`, `vb_bot2`, `vb_x2`.
- R6: `ctl_sel` chooses what drives `ctl_pin`: 2'b00 gives vertical sync, 2'b01 gives vertical blank, and 2'b10 or 2'b11 give the inactive level. `ctl_pin` equals the chosen active level XOR `ctl_pol`, so `ctl_pol` = 1 makes the pin active-low.
- R7: `fld1_start` is high for exactly the one cycle after the enabled pixel at (`fs_line1`, `fs_pix1`). `fld2_start` does the same for (`fs_line2`, `fs_pix2`).
- R8: The image region of field k begins at line `vbit_offk` + `img_offk`. On that line `img_line` becomes 0, and it then rises by one each line until it reaches `img_lenk`, where it stays. `img_active` is high exactly while `img_line` is below the current field's length.
- R9: On a cycle with `pix_en` low, no output changes except `ctl_pin` (which follows `ctl_sel` and `ctl_pol`), and the strobes read 0. An event takes effect only when both its line and its pixel position match.
- R10: With `rst` high, `v_bit`, `f_bit`, the strobes and `img_active` are 0, `img_line` equals `img_len1`, and `ctl_pin` equals `ctl_pol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | Pixel-count enable |
| hpos | input | PIX_W | Current horizontal pixel position |
| frm_height | input | LINE_W | Lines per frame |
| vbit_on1 | input | LINE_W | Field 1 blanking bit set line |
| vbit_off1 | input | LINE_W | Field 1 blanking bit clear line |
| vbit_on2 | input | LINE_W | Field 2 blanking bit set line |
| vbit_off2 | input | LINE_W | Field 2 blanking bit clear line |
| fbit_on | input | LINE_W | Field bit set line |
| fbit_off | input | LINE_W | Field bit clear line |
| vs_top1 | input | LINE_W | Field 1 sync start line |
| vs_bot1 | input | LINE_W | Field 1 sync stop line |
| vs_x1 | input | PIX_W | Field 1 sync pixel position |
| vs_top2 | input | LINE_W | Field 2 sync start line |
| vs_bot2 | input | LINE_W | Field 2 sync stop line |
| vs_x2 | input | PIX_W | Field 2 sync pixel position |
| vb_top1 | input | LINE_W | Field 1 blank start line |
| vb_bot1 | input | LINE_W | Field 1 blank stop line |
| vb_x1 | input | PIX_W | Field 1 blank pixel position |
| vb_top2 | input | LINE_W | Field 2 blank start line |
| vb_bot2 | input | LINE_W | Field 2 blank stop line |
| vb_x2 | input | PIX_W | Field 2 blank pixel position |
| fs_line1 | input | LINE_W | Field 1 start line |
| fs_pix1 | input | PIX_W | Field 1 start pixel |
| fs_line2 | input | LINE_W | Field 2 start line |
| fs_pix2 | input | PIX_W | Field 2 start pixel |
| img_off1 | input | LINE_W | Field 1 image offset from the blanking clear line |
| img_len1 | input | LINE_W | Field 1 image line count |
| img_off2 | input | LINE_W | Field 2 image offset from the blanking clear line |
| img_len2 | input | LINE_W | Field 2 image line count |
| ctl_sel | input | 2 | Control pin source select |
| ctl_pol | input | 1 | Control pin polarity (1 = active-low) |
| v_bit | output | 1 | Vertical blanking bit |
| f_bit | output | 1 | Field bit |
| ctl_pin | output | 1 | External sync or blank pin |
| fld1_start | output | 1 | Field 1 start strobe |
| fld2_start | output | 1 | Field 2 start strobe |
| img_line | output | LINE_W | Image line count |
| img_active | output | 1 | Current line is an image line |

## Verification
The bench uses the default widths (LINE_W = 10, PIX_W = 12) and programs a 525-line frame. It drives a short line of 16 pixel positions, so two complete frames fit in about twenty thousand cycles while the vertical event lines keep their usual values. First-field events sit at pixel 12 and second-field events at pixel 4, which places the second-field sync and blank edges part way along a line. Idle cycles are inserted, some of them with `hpos` at 0, and the control pin select and polarity are switched through all four codes. This exercises the frame wrap, the field bit window that crosses that wrap, and the saturation of the image counter.

// File: rtl/vft_pkg.sv
package vft_pkg;
  // window slots built from (line, pixel) set/clear pairs
  localparam int NUM_WIN = 7;
  localparam int W_V1  = 0;
  localparam int W_V2  = 1;
  localparam int W_F   = 2;
  localparam int W_VS1 = 3;
  localparam int W_VS2 = 4;
  localparam int W_VB1 = 5;
  localparam int W_VB2 = 6;

  typedef enum logic [1:0] {
    CTL_VSYNC  = 2'b00,
    CTL_VBLANK = 2'b01,
    CTL_IDLE_A = 2'b10,
    CTL_IDLE_B = 2'b11
  } ctl_sel_e;
endpackage

// File: rtl/vft_line_ctr.sv
module vft_line_ctr #(
  parameter int LINE_W = 10,
  parameter int PIX_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pix_en,
  input  logic [PIX_W-1:0]  hpos,
  input  logic [LINE_W-1:0] frm_height,
  output logic              line_step,
  output logic [LINE_W-1:0] cur_line
);
  logic [LINE_W-1:0] line_q;
  logic [LINE_W-1:0] line_nxt;

  assign line_step = pix_en && (hpos == '0);
  // line 0 only exists after reset; anything at or past the height wraps
  assign line_nxt  = (line_q >= frm_height) ? LINE_W'(1) : line_q + LINE_W'(1);
  assign cur_line  = line_step ? line_nxt : line_q;

  always_ff @(posedge clk) begin
    if (rst)            line_q <= '0;
    else if (line_step) line_q <= line_nxt;
  end
endmodule

// File: rtl/vft_window.sv
module vft_window #(
  parameter int LINE_W = 10,
  parameter int PIX_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pix_en,
  input  logic [LINE_W-1:0] cur_line,
  input  logic [PIX_W-1:0]  hpos,
  input  logic [LINE_W-1:0] set_y,
  input  logic [PIX_W-1:0]  set_x,
  input  logic [LINE_W-1:0] clr_y,
  input  logic [PIX_W-1:0]  clr_x,
  output logic              flag_d
);
  logic flag_q;
  logic hit_set;
  logic hit_clr;

  assign hit_set = pix_en && (cur_line == set_y) && (hpos == set_x);
  assign hit_clr = pix_en && (cur_line == clr_y) && (hpos == clr_x);

  always_comb begin
    flag_d = flag_q;
    if (hit_set)      flag_d = 1'b1;
    else if (hit_clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= flag_d;
  end
endmodule

// File: rtl/vft_image_ctr.sv
module vft_image_ctr #(
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_step,
  input  logic [LINE_W-1:0] cur_line,
  input  logic [LINE_W-1:0] first1,
  input  logic [LINE_W-1:0] first2,
  input  logic [LINE_W-1:0] len1,
  input  logic [LINE_W-1:0] len2,
  output logic [LINE_W-1:0] img_line,
  output logic              img_active
);
  logic              fld_q, fld_d;
  logic [LINE_W-1:0] cnt_q, cnt_d;
  logic [LINE_W-1:0] len_q, len_d;

  assign len_q = fld_q ? len2 : len1;
  assign len_d = fld_d ? len2 : len1;

  always_comb begin
    fld_d = fld_q;
    cnt_d = cnt_q;
    if (line_step) begin
      if (cur_line == first1) begin
        fld_d = 1'b0;
        cnt_d = '0;
      end else if (cur_line == first2) begin
        fld_d = 1'b1;
        cnt_d = '0;
      end else if (cnt_q < len_q) begin
        cnt_d = cnt_q + LINE_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fld_q      <= 1'b0;
      cnt_q      <= len1;
      img_active <= 1'b0;
    end else begin
      fld_q      <= fld_d;
      cnt_q      <= cnt_d;
      img_active <= cnt_d < len_d;
    end
  end

  assign img_line = cnt_q;
endmodule

// File: rtl/vfield_timing_gen.sv
module vfield_timing_gen
  import vft_pkg::*;
#(
  parameter int LINE_W = 10,
  parameter int PIX_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pix_en,
  input  logic [PIX_W-1:0]  hpos,
  input  logic [LINE_W-1:0] frm_height,
  input  logic [LINE_W-1:0] vbit_on1,
  input  logic [LINE_W-1:0] vbit_off1,
  input  logic [LINE_W-1:0] vbit_on2,
  input  logic [LINE_W-1:0] vbit_off2,
  input  logic [LINE_W-1:0] fbit_on,
  input  logic [LINE_W-1:0] fbit_off,
  input  logic [LINE_W-1:0] vs_top1,
  input  logic [LINE_W-1:0] vs_bot1,
  input  logic [PIX_W-1:0]  vs_x1,
  input  logic [LINE_W-1:0] vs_top2,
  input  logic [LINE_W-1:0] vs_bot2,
  input  logic [PIX_W-1:0]  vs_x2,
  input  logic [LINE_W-1:0] vb_top1,
  input  logic [LINE_W-1:0] vb_bot1,
  input  logic [PIX_W-1:0]  vb_x1,
  input  logic [LINE_W-1:0] vb_top2,
  input  logic [LINE_W-1:0] vb_bot2,
  input  logic [PIX_W-1:0]  vb_x2,
  input  logic [LINE_W-1:0] fs_line1,
  input  logic [PIX_W-1:0]  fs_pix1,
  input  logic [LINE_W-1:0] fs_line2,
  input  logic [PIX_W-1:0]  fs_pix2,
  input  logic [LINE_W-1:0] img_off1,
  input  logic [LINE_W-1:0] img_len1,
  input  logic [LINE_W-1:0] img_off2,
  input  logic [LINE_W-1:0] img_len2,
  input  logic [1:0]        ctl_sel,
  input  logic              ctl_pol,
  output logic              v_bit,
  output logic              f_bit,
  output logic              ctl_pin,
  output logic              fld1_start,
  output logic              fld2_start,
  output logic [LINE_W-1:0] img_line,
  output logic              img_active
);
  logic              line_step;
  logic [LINE_W-1:0] cur_line;

  logic [LINE_W-1:0] set_y [NUM_WIN];
  logic [PIX_W-1:0]  set_x [NUM_WIN];
  logic [LINE_W-1:0] clr_y [NUM_WIN];
  logic [PIX_W-1:0]  clr_x [NUM_WIN];
  logic [NUM_WIN-1:0] win_d;

  logic sync_d, blank_d, ctl_lvl;

  vft_line_ctr #(.LINE_W(LINE_W), .PIX_W(PIX_W)) u_line (
    .clk(clk), .rst(rst), .pix_en(pix_en), .hpos(hpos),
    .frm_height(frm_height), .line_step(line_step), .cur_line(cur_line)
  );

  // blanking and field bits change on line boundaries only
  assign set_y[W_V1] = vbit_on1;  assign set_x[W_V1] = '0;
  assign clr_y[W_V1] = vbit_off1; assign clr_x[W_V1] = '0;
  assign set_y[W_V2] = vbit_on2;  assign set_x[W_V2] = '0;
  assign clr_y[W_V2] = vbit_off2; assign clr_x[W_V2] = '0;
  assign set_y[W_F]  = fbit_on;   assign set_x[W_F]  = '0;
  assign clr_y[W_F]  = fbit_off;  assign clr_x[W_F]  = '0;
  // sync and blank windows share one pixel position per field
  assign set_y[W_VS1] = vs_top1; assign set_x[W_VS1] = vs_x1;
  assign clr_y[W_VS1] = vs_bot1; assign clr_x[W_VS1] = vs_x1;
  assign set_y[W_VS2] = vs_top2; assign set_x[W_VS2] = vs_x2;
  assign clr_y[W_VS2] = vs_bot2; assign clr_x[W_VS2] = vs_x2;
  assign set_y[W_VB1] = vb_top1; assign set_x[W_VB1] = vb_x1;
  assign clr_y[W_VB1] = vb_bot1; assign clr_x[W_VB1] = vb_x1;
  assign set_y[W_VB2] = vb_top2; assign set_x[W_VB2] = vb_x2;
  assign clr_y[W_VB2] = vb_bot2; assign clr_x[W_VB2] = vb_x2;

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    vft_window #(.LINE_W(LINE_W), .PIX_W(PIX_W)) u_win (
      .clk(clk), .rst(rst), .pix_en(pix_en), .cur_line(cur_line), .hpos(hpos),
      .set_y(set_y[i]), .set_x(set_x[i]), .clr_y(clr_y[i]), .clr_x(clr_x[i]),
      .flag_d(win_d[i])
    );
  end

  vft_image_ctr #(.LINE_W(LINE_W)) u_img (
    .clk(clk), .rst(rst), .line_step(line_step), .cur_line(cur_line),
    .first1(vbit_off1 + img_off1), .first2(vbit_off2 + img_off2),
    .len1(img_len1), .len2(img_len2),
    .img_line(img_line), .img_active(img_active)
  );

  assign sync_d  = win_d[W_VS1] | win_d[W_VS2];
  assign blank_d = win_d[W_VB1] | win_d[W_VB2];

  always_comb begin
    unique case (ctl_sel_e'(ctl_sel))
      CTL_VSYNC:  ctl_lvl = sync_d;
      CTL_VBLANK: ctl_lvl = blank_d;
      default:    ctl_lvl = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_bit      <= 1'b0;
      f_bit      <= 1'b0;
      ctl_pin    <= ctl_pol;
      fld1_start <= 1'b0;
      fld2_start <= 1'b0;
    end else begin
      v_bit      <= win_d[W_V1] | win_d[W_V2];
      f_bit      <= win_d[W_F];
      ctl_pin    <= ctl_lvl ^ ctl_pol;
      fld1_start <= pix_en && (cur_line == fs_line1) && (hpos == fs_pix1);
      fld2_start <= pix_en && (cur_line == fs_line2) && (hpos == fs_pix2);
    end
  end
endmodule

// File: rtl/vft_checker.sv
module vft_checker #(
  parameter int LINE_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              pix_en,
  input logic [1:0]        ctl_sel,
  input logic              ctl_pol,
  input logic [LINE_W-1:0] img_len1,
  input logic [LINE_W-1:0] img_len2,
  input logic              v_bit,
  input logic              f_bit,
  input logic              ctl_pin,
  input logic              fld1_start,
  input logic              fld2_start,
  input logic [LINE_W-1:0] img_line,
  input logic              img_active
);
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !pix_en |=> ($stable(v_bit) && $stable(f_bit) && $stable(img_line) && $stable(img_active)));

  p_strobe_needs_en_r7: assert property (@(posedge clk) disable iff (rst)
    (fld1_start || fld2_start) |-> $past(pix_en));

  p_ctl_idle_r6: assert property (@(posedge clk) disable iff (rst)
    ctl_sel[1] |=> (ctl_pin == $past(ctl_pol)));

  p_img_first_zero_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(img_active) |-> (img_line == '0));

  p_img_hold_len_r8: assert property (@(posedge clk) disable iff (rst)
    !img_active |-> (img_line == img_len1 || img_line == img_len2));
endmodule

bind vfield_timing_gen vft_checker #(.LINE_W(LINE_W)) i_vft_chk (
  .clk(clk), .rst(rst), .pix_en(pix_en), .ctl_sel(ctl_sel), .ctl_pol(ctl_pol),
  .img_len1(img_len1), .img_len2(img_len2), .v_bit(v_bit), .f_bit(f_bit),
  .ctl_pin(ctl_pin), .fld1_start(fld1_start), .fld2_start(fld2_start),
  .img_line(img_line), .img_active(img_active)
);

// File: tb/test_vfield_timing_gen.sv
module test_vfield_timing_gen;
  localparam int LINE_W = 10;
  localparam int PIX_W  = 12;
  localparam int L = 16;
  localparam int H = 525;
  localparam int T = L * H;
  localparam int X1 = 12;
  localparam int X2 = 4;
  localparam int ILEN = 240;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pix_en = 1'b0;
  logic [PIX_W-1:0] hpos = '0;
  logic [1:0] ctl_sel = 2'b00;
  logic ctl_pol = 1'b1;
  logic v_bit, f_bit, ctl_pin, fld1_start, fld2_start, img_active;
  logic [LINE_W-1:0] img_line;

  int checks = 0;
  int errors = 0;
  int nproc = -1;
  bit done = 0;

  typedef struct packed {
    logic v, f, ctl, fs1, fs2, act, idle;
    logic [1:0] sel;
    logic [LINE_W-1:0] ln;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  vfield_timing_gen #(.LINE_W(LINE_W), .PIX_W(PIX_W)) i_vfield_timing_gen (
    .clk(clk), .rst(rst), .pix_en(pix_en), .hpos(hpos),
    .frm_height(10'd525),
    .vbit_on1(10'd1), .vbit_off1(10'd20), .vbit_on2(10'd264), .vbit_off2(10'd283),
    .fbit_on(10'd266), .fbit_off(10'd4),
    .vs_top1(10'd4), .vs_bot1(10'd7), .vs_x1(12'(X1)),
    .vs_top2(10'd266), .vs_bot2(10'd269), .vs_x2(12'(X2)),
    .vb_top1(10'd1), .vb_bot1(10'd20), .vb_x1(12'(X1)),
    .vb_top2(10'd263), .vb_bot2(10'd283), .vb_x2(12'(X2)),
    .fs_line1(10'd1), .fs_pix1(12'(X1)), .fs_line2(10'd263), .fs_pix2(12'(X2)),
    .img_off1(10'd3), .img_len1(10'(ILEN)), .img_off2(10'd3), .img_len2(10'(ILEN)),
    .ctl_sel(ctl_sel), .ctl_pol(ctl_pol),
    .v_bit(v_bit), .f_bit(f_bit), .ctl_pin(ctl_pin),
    .fld1_start(fld1_start), .fld2_start(fld2_start),
    .img_line(img_line), .img_active(img_active)
  );

  function automatic int pos(int y, int x);
    return (y - 1) * L + x;
  endfunction

  // most recent absolute index <= n where position q of a frame occurred
  function automatic int last_occ(int n, int qq);
    int m, r;
    if (n < 0) return -1;
    m = n % T;
    r = (m >= qq) ? n - m + qq : n - m + qq - T;
    return (r < 0) ? -1 : r;
  endfunction

  function automatic bit in_win(int n, int s, int c);
    int ls, lc;
    ls = last_occ(n, s);
    lc = last_occ(n, c);
    return (ls >= 0) && (ls >= lc);
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      if (errors <= 20) $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // driver: applies one cycle of stimulus and queues the post-edge expectation
  task automatic drive(bit en, int k, logic [1:0] sel, bit pol);
    exp_t e;
    int m, ln;
    bit vs, vb, lvl;
    pix_en  = en;
    hpos    = en ? PIX_W'(k % L) : '0;
    ctl_sel = sel;
    ctl_pol = pol;
    if (en) nproc = k;
    e.idle = !en;
    e.sel  = sel;
    e.v = in_win(nproc, pos(1, 0), pos(20, 0)) | in_win(nproc, pos(264, 0), pos(283, 0));
    e.f = in_win(nproc, pos(266, 0), pos(4, 0));
    vs  = in_win(nproc, pos(4, X1), pos(7, X1)) | in_win(nproc, pos(266, X2), pos(269, X2));
    vb  = in_win(nproc, pos(1, X1), pos(20, X1)) | in_win(nproc, pos(263, X2), pos(283, X2));
    lvl = (sel == 2'b00) ? vs : (sel == 2'b01) ? vb : 1'b0;
    e.ctl = lvl ^ pol;
    e.fs1 = en && (k % T == pos(1, X1));
    e.fs2 = en && (k % T == pos(263, X2));
    e.act = 1'b0;
    e.ln  = LINE_W'(ILEN);
    if (nproc >= 0) begin
      m  = nproc % T;
      ln = m / L + 1;
      if (ln >= 23 && ln < 23 + ILEN) begin
        e.act = 1'b1; e.ln = LINE_W'(ln - 23);
      end else if (ln >= 286 && ln < 286 + ILEN) begin
        e.act = 1'b1; e.ln = LINE_W'(ln - 286);
      end
    end
    q.push_back(e);
  endtask

  // monitor: compares each queued expectation just after the edge it belongs to
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        check(v_bit == e.v, e.idle ? "R9 R2 R1 v_bit" : "R2 R1 v_bit", v_bit, e.v);
        check(f_bit == e.f, e.idle ? "R9 R3 f_bit" : "R3 f_bit", f_bit, e.f);
        if (e.sel == 2'b00)      check(ctl_pin == e.ctl, "R4 R6 ctl_pin sync", ctl_pin, e.ctl);
        else if (e.sel == 2'b01) check(ctl_pin == e.ctl, "R5 R6 ctl_pin blank", ctl_pin, e.ctl);
        else                     check(ctl_pin == e.ctl, "R6 ctl_pin idle select", ctl_pin, e.ctl);
        check(fld1_start == e.fs1, "R7 fld1_start", fld1_start, e.fs1);
        check(fld2_start == e.fs2, "R7 fld2_start", fld2_start, e.fs2);
        check(img_line == e.ln, e.idle ? "R9 R8 img_line" : "R8 img_line", img_line, e.ln);
        check(img_active == e.act, "R8 img_active", img_active, e.act);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [1:0] sel;
    bit pol;
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state, with active-low polarity selected
    check(v_bit == 1'b0, "R10 v_bit", v_bit, 0);
    check(f_bit == 1'b0, "R10 f_bit", f_bit, 0);
    check(ctl_pin == 1'b1, "R10 ctl_pin", ctl_pin, 1);
    check(fld1_start == 1'b0 && fld2_start == 1'b0, "R10 strobes", fld1_start | fld2_start, 0);
    check(img_line == LINE_W'(ILEN), "R10 img_line", img_line, ILEN);
    check(img_active == 1'b0, "R10 img_active", img_active, 0);
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 2 * T + 32; k++) begin
      if (k < T)                  begin sel = 2'b00; pol = 1'b0; end
      else if (k < T + T / 2)     begin sel = 2'b01; pol = 1'b1; end
      else if (k < T + 3 * T / 4) begin sel = 2'b10; pol = 1'b1; end
      else                        begin sel = 2'b11; pol = 1'b0; end
      if (k % 5 == 4) begin
        drive(1'b0, k, sel, pol);
        @(negedge clk);
      end
      drive(1'b1, k, sel, pol);
      @(negedge clk);
    end
    pix_en = 1'b0;
    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule